// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the master side of a 1-Wire bus. It pulls an open-drain line low through an output enable (`bus_oe`) and reads the line back on `bus_in`. All bus timing is counted in ticks of a time base. A divider produces one tick every `clk_div`+1 system clocks, so with the right factor a tick is one microsecond. Six configuration inputs give, in ticks, the reset low time, the presence sample point, the low time for a 0 bit and for a 1 bit, the read sample point and the full slot length.

Software loads bytes into a 16-entry transmit queue and starts an operation with a single-cycle command strobe. A reset command holds the line low, releases it, samples for a presence answer and latches the result. A go command takes one byte from the transmit queue. In bit mode it runs one slot using bit 0 of that byte. In byte mode it runs eight slots, least significant bit first. In every slot the line is sampled, so a read is a slot that writes a 1. The sampled bits go into a 16-entry receive queue. A third mode turns the sequencer off and lets software drive the line directly.

The sequencer has six states:
- IDLE
- RST_LOW
- RST_HIGH
- SLOT_LOW
- SLOT_HIGH
- DONE

Transitions:
- IDLE→RST_LOW on an accepted reset command.
- IDLE→SLOT_LOW on an accepted go command.
- RST_LOW→RST_HIGH after the reset low time.
- RST_HIGH→DONE after the same number of ticks with the line released.
- SLOT_LOW→SLOT_HIGH after the bit's low time.
- SLOT_HIGH→SLOT_LOW when the slot ends and bits remain.
- SLOT_HIGH→DONE after the last slot.
- DONE→IDLE always.

Top module: `onewire_master`

## Requirements
- R1: After reset, `bus_oe`, `busy`, `done`, `presence`, `tx_ovf`, `rx_udf`, `err` and `tx_full` are 0, `rx_empty` is 1 and `rx_data` is 0.
- R2: A reset command holds `bus_oe` high for `t_reset_low`×(`clk_div`+1) clocks, then leaves it released for the same time. `presence` becomes 1 if `bus_in` is 0 at tick `t_presence` after release, and 0 otherwise. `busy` lasts 2×`t_reset_low`×(`clk_div`+1)+1 clocks, and `done` is set at its end.
- R3: Each slot drives `bus_oe` for `t_low0` ticks when the bit is 0 and `t_low1` ticks when the bit is 1. Each slot lasts `t_slot` ticks.
- R4: In byte mode (`mode`=1), one go command sends the popped byte least significant bit first as 8 slots. It pushes one receive byte whose bit i is the line value sampled in slot i. `busy` lasts 8×`t_slot`×(`clk_div`+1)+1 clocks.
- R5: In bit mode (`mode`=0, and also `mode`=3), one go command runs a single slot from bit 0 of the popped byte. It pushes {7'b0, sampled bit}.
- R6: The line is sampled at tick `t_sample` of each slot. A device holding the line low there yields a 0 bit.
- R7: Each queue keeps first-in first-out order for 16 entries. A `tx_wr` while `tx_full` is 1 is dropped and sets `tx_ovf`.
- R8: An `rx_rd` while `rx_empty` is 1 returns `rx_data`=0 and sets `rx_udf`.
- R9: A go command with an empty transmit queue starts nothing and sets `err`. A receive push into a full receive queue is dropped and sets `err`.
- R10: In bypass mode (`mode`=2), `bus_oe` follows `bypass_drive`. Reset and go commands are ignored and pop nothing.
- R11: `flag_clr` clears `done`, `tx_ovf`, `rx_udf` and `err`. A flag being set in the same cycle wins.
- R12: With `clk_div`=0 one tick equals one clock, so all durations scale to (`clk_div`+1) clocks per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 bit, 1 byte, 2 bypass, 3 bit |
| clk_div | input | 8 | Tick period minus one, in clocks |
| t_reset_low | input | 10 | Reset low time and release window, ticks |
| t_presence | input | 10 | Presence sample point after release, ticks |
| t_low0 | input | 10 | Low time of a 0 slot, ticks |
| t_low1 | input | 10 | Low time of a 1 or read slot, ticks |
| t_sample | input | 10 | Read sample point from slot start, ticks |
| t_slot | input | 10 | Full slot length, ticks |
| bypass_drive | input | 1 | Line drive in bypass mode |
| cmd_reset | input | 1 | Start a reset/presence sequence |
| cmd_go | input | 1 | Start a bit or byte transfer |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the receive queue |
| rx_data | output | 8 | Receive queue head, 0 when empty |
| rx_empty | output | 1 | Receive queue empty |
| flag_clr | input | 1 | Clear the sticky flags |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | Sticky: an operation finished |
| presence | output | 1 | Result of the last presence sample |
| tx_ovf | output | 1 | Sticky: transmit write dropped |
| rx_udf | output | 1 | Sticky: read of an empty receive queue |
| err | output | 1 | Sticky: empty go or receive overflow |
| bus_oe | output | 1 | Pull the line low |
| bus_in | input | 1 | Sensed line level |

## Verification
A fault in the tick counter or in the slot counter shows up at once as a wrong `bus_oe` pulse width or a wrong `busy` length, within the first slot. A shift register or bit index that has gone astray does not show up until the receive byte is read. It appears as a bit-order error or as the wrong number of low pulses in the sequence of measured pulses. Queue pointer faults appear only when entries are read back, many operations later. For that reason the queue test fills both queues to depth before draining them.

// File: rtl/owm_pkg.sv
package owm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_HIGH,
        ST_SLOT_LOW,
        ST_SLOT_HIGH,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] MODE_BIT    = 2'd0;
    localparam logic [1:0] MODE_BYTE   = 2'd1;
    localparam logic [1:0] MODE_BYPASS = 2'd2;
endpackage

// File: rtl/owm_fifo.sv
module owm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [AW:0]      cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
            if (do_push && !do_pop)      cnt_q <= cnt_q + (AW+1)'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - (AW+1)'(1);
        end
    end
endmodule

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || tick)    cnt_q <= '0;
        else                      cnt_q <= cnt_q + DIVW'(1);
    end
endmodule

// File: rtl/owm_seq.sv
module owm_seq
    import owm_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_rst,
    input  logic          start_go,
    input  logic          byte_mode,
    input  logic [TW-1:0] t_rst,
    input  logic [TW-1:0] t_pres,
    input  logic [TW-1:0] t_w0,
    input  logic [TW-1:0] t_w1,
    input  logic [TW-1:0] t_smp,
    input  logic [TW-1:0] t_slot,
    input  logic [7:0]    tx_byte,
    input  logic          bus_in,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [7:0]    rx_byte,
    output logic          line_low,
    output logic          run,
    output logic          busy,
    output logic          done_pulse,
    output logic          pres_out
);
    seq_state_t    st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_inc, lo_lim;
    logic [2:0]    bit_q;
    logic [7:0]    txsh_q, rxsh_q;
    logic          samp_q, xfer_q, byte_q, pres_q;
    logic          in_slot, smp_hit, samp_now, last_bit, keep_cnt, slot_end;

    assign cnt_inc  = cnt_q + TW'(1);
    assign lo_lim   = txsh_q[0] ? t_w1 : t_w0;
    assign in_slot  = (st_q == ST_SLOT_LOW) || (st_q == ST_SLOT_HIGH);
    assign smp_hit  = tick && in_slot && (cnt_inc == t_smp);
    assign samp_now = smp_hit ? bus_in : samp_q;
    assign last_bit = byte_q ? (bit_q == 3'd7) : 1'b1;
    assign slot_end = (st_q == ST_SLOT_HIGH) && tick && (cnt_inc == t_slot);
    assign keep_cnt = (st_q == ST_SLOT_LOW) && (st_d == ST_SLOT_HIGH);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_rst)     st_d = ST_RST_LOW;
                else if (start_go) st_d = ST_SLOT_LOW;
            end
            ST_RST_LOW:   if (tick && cnt_inc == t_rst)  st_d = ST_RST_HIGH;
            ST_RST_HIGH:  if (tick && cnt_inc == t_rst)  st_d = ST_DONE;
            ST_SLOT_LOW:  if (tick && cnt_inc == lo_lim) st_d = ST_SLOT_HIGH;
            ST_SLOT_HIGH: if (slot_end) st_d = last_bit ? ST_DONE : ST_SLOT_LOW;
            ST_DONE:      st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // timing counter and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
            samp_q <= 1'b1;
            xfer_q <= 1'b0;
            byte_q <= 1'b0;
            pres_q <= 1'b0;
        end else begin
            if (st_d != st_q && !keep_cnt) cnt_q <= '0;
            else if (tick)                 cnt_q <= cnt_inc;

            if (smp_hit) samp_q <= bus_in;

            if (st_q == ST_IDLE && start_rst) begin
                xfer_q <= 1'b0;
            end else if (st_q == ST_IDLE && start_go) begin
                txsh_q <= tx_byte;
                bit_q  <= '0;
                xfer_q <= 1'b1;
                byte_q <= byte_mode;
            end

            if (slot_end) begin
                rxsh_q <= {samp_now, rxsh_q[7:1]};
                txsh_q <= {1'b0, txsh_q[7:1]};
                bit_q  <= bit_q + 3'd1;
            end

            if (st_q == ST_RST_HIGH && tick && cnt_inc == t_pres) pres_q <= ~bus_in;
        end
    end

    // outputs
    always_comb begin
        line_low   = (st_q == ST_RST_LOW) || (st_q == ST_SLOT_LOW);
        run        = (st_q != ST_IDLE) && (st_q != ST_DONE);
        busy       = (st_q != ST_IDLE);
        tx_pop     = (st_q == ST_IDLE) && start_go && !start_rst;
        done_pulse = (st_q == ST_DONE);
        rx_push    = (st_q == ST_DONE) && xfer_q;
        rx_byte    = byte_q ? rxsh_q : {7'b0, rxsh_q[7]};
        pres_out   = pres_q;
    end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
    import owm_pkg::*;
#(
    parameter int DIVW  = 8,
    parameter int TW    = 10,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [DIVW-1:0] clk_div,
    input  logic [TW-1:0]   t_reset_low,
    input  logic [TW-1:0]   t_presence,
    input  logic [TW-1:0]   t_low0,
    input  logic [TW-1:0]   t_low1,
    input  logic [TW-1:0]   t_sample,
    input  logic [TW-1:0]   t_slot,
    input  logic            bypass_drive,
    input  logic            cmd_reset,
    input  logic            cmd_go,
    input  logic            tx_wr,
    input  logic [7:0]      tx_data,
    output logic            tx_full,
    input  logic            rx_rd,
    output logic [7:0]      rx_data,
    output logic            rx_empty,
    input  logic            flag_clr,
    output logic            busy,
    output logic            done,
    output logic            presence,
    output logic            tx_ovf,
    output logic            rx_udf,
    output logic            err,
    output logic            bus_oe,
    input  logic            bus_in
);
    logic       tick, run, line_low, seq_busy, done_pulse;
    logic       tx_empty_w, tx_pop, rx_push, rx_full_w;
    logic       is_byp, rst_ok, go_ok, go_err, rx_drop;
    logic [7:0] tx_head, rx_head, rx_byte;

    assign is_byp  = (mode == MODE_BYPASS);
    assign rst_ok  = cmd_reset && !is_byp;
    assign go_ok   = cmd_go && !cmd_reset && !is_byp && !tx_empty_w;
    assign go_err  = cmd_go && !cmd_reset && !is_byp && !seq_busy && tx_empty_w;
    assign rx_drop = rx_push && rx_full_w;

    owm_tick #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
    );

    owm_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty_w)
    );

    owm_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
        .pop(rx_rd), .rdata(rx_head), .full(rx_full_w), .empty(rx_empty)
    );

    owm_seq #(.TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_rst(rst_ok), .start_go(go_ok), .byte_mode(mode == MODE_BYTE),
        .t_rst(t_reset_low), .t_pres(t_presence), .t_w0(t_low0), .t_w1(t_low1),
        .t_smp(t_sample), .t_slot(t_slot), .tx_byte(tx_head), .bus_in(bus_in),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .line_low(line_low), .run(run), .busy(seq_busy),
        .done_pulse(done_pulse), .pres_out(presence)
    );

    assign busy    = seq_busy;
    assign rx_data = rx_empty ? 8'h00 : rx_head;
    assign bus_oe  = line_low || (is_byp && !seq_busy && bypass_drive);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            tx_ovf <= 1'b0;
            rx_udf <= 1'b0;
            err    <= 1'b0;
        end else begin
            done   <= done_pulse            || (done   && !flag_clr);
            tx_ovf <= (tx_wr && tx_full)    || (tx_ovf && !flag_clr);
            rx_udf <= (rx_rd && rx_empty)   || (rx_udf && !flag_clr);
            err    <= go_err || rx_drop     || (err    && !flag_clr);
        end
    end
endmodule

// File: rtl/owm_checker.sv
module owm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       cmd_reset,
    input logic       cmd_go,
    input logic       tx_wr,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       rx_rd,
    input logic       rx_empty,
    input logic       busy,
    input logic       done,
    input logic       tx_ovf,
    input logic       rx_udf,
    input logic       err,
    input logic       bus_oe
);
    assert_quiet_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode != 2'd2) |-> !bus_oe);

    assert_done_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !cmd_reset && mode != 2'd2 && !busy && !tx_empty) |=> busy);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full) |=> tx_ovf);

    assert_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_empty) |=> rx_udf);

    assert_empty_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !cmd_reset && mode != 2'd2 && !busy && tx_empty) |=> (err && !busy));

    assert_bypass_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !busy && (cmd_go || cmd_reset)) |=> !busy);
endmodule

bind onewire_master owm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cmd_reset(cmd_reset), .cmd_go(cmd_go),
    .tx_wr(tx_wr), .tx_full(tx_full), .tx_empty(tx_empty_w), .rx_rd(rx_rd),
    .rx_empty(rx_empty), .busy(busy), .done(done), .tx_ovf(tx_ovf),
    .rx_udf(rx_udf), .err(err), .bus_oe(bus_oe)
);

// File: tb/sim_onewire_master.sv
`timescale 1ns/1ps
module sim_onewire_master;
    logic       clk = 0, rst_n = 0;
    logic [1:0] mode = 2'd1;
    logic [7:0] clk_div = 8'd1;
    logic [9:0] t_reset_low = 10'd20, t_presence = 10'd7, t_low0 = 10'd6;
    logic [9:0] t_low1 = 10'd1, t_sample = 10'd3, t_slot = 10'd8;
    logic       bypass_drive = 0, cmd_reset = 0, cmd_go = 0, tx_wr = 0, rx_rd = 0, flag_clr = 0;
    logic [7:0] tx_data = 0;
    logic       tx_full, rx_empty, busy, done, presence, tx_ovf, rx_udf, err, bus_oe;
    logic [7:0] rx_data;
    logic       dev_low = 0, dev_force = 0, prev_oe = 0;
    logic       bus_in;
    int         tests = 0, fails = 0, hold = 0, width = 0;
    bit         finished = 0;
    int         exp_w[$];
    int         exp_rx[$];
    bit         resp_q[$];

    always #2 clk = ~clk;
    assign bus_in = !(bus_oe || dev_low || dev_force);

    onewire_master u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .clk_div(clk_div),
        .t_reset_low(t_reset_low), .t_presence(t_presence), .t_low0(t_low0),
        .t_low1(t_low1), .t_sample(t_sample), .t_slot(t_slot),
        .bypass_drive(bypass_drive), .cmd_reset(cmd_reset), .cmd_go(cmd_go),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_empty(rx_empty), .flag_clr(flag_clr), .busy(busy),
        .done(done), .presence(presence), .tx_ovf(tx_ovf), .rx_udf(rx_udf),
        .err(err), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model: answers read slots from resp_q
    always @(negedge clk) begin
        if (hold > 0) hold--;
        if (!prev_oe && bus_oe && resp_q.size() > 0) begin
            if (!resp_q.pop_front()) hold = t_sample * (clk_div + 1) + 1;
        end
        dev_low = (hold > 0);
        prev_oe = bus_oe;
    end

    // monitor: scoreboard of low pulse widths
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_oe) width++;
            else if (width > 0) begin
                if (exp_w.size() == 0) chk("R3 unexpected pulse", width, 0);
                else chk("R3/R2/R10 pulse width", width, exp_w.pop_front());
                width = 0;
            end
        end
    end

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic expect_byte(input logic [7:0] b, input bit byte_mode);
        int d = clk_div + 1;
        int n = byte_mode ? 8 : 1;
        for (int i = 0; i < n; i++) exp_w.push_back((b[i] ? t_low1 : t_low0) * d);
    endtask

    task automatic pulse_cmd(input bit is_reset, output int busy_cyc);
        @(negedge clk);
        if (is_reset) cmd_reset = 1; else cmd_go = 1;
        @(negedge clk);
        cmd_reset = 0; cmd_go = 0;
        busy_cyc = 0;
        while (busy) begin busy_cyc++; @(negedge clk); end
    endtask

    task automatic read_rx(string req);
        @(negedge clk);
        if (exp_rx.size() == 0) chk({req, " rx scoreboard empty"}, 1, 0);
        else chk({req, " rx byte"}, rx_data, exp_rx.pop_front());
        rx_rd = 1;
        @(negedge clk); rx_rd = 0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int bc;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 bus_oe", bus_oe, 0);   chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);       chk("R1 presence", presence, 0);
        chk("R1 flags", {tx_ovf, rx_udf, err, tx_full}, 0);
        chk("R1 rx_empty", rx_empty, 1); chk("R1 rx_data", rx_data, 0);

        // R2 reset with presence answer
        dev_force = 1;
        exp_w.push_back(20 * 2);
        pulse_cmd(1, bc);
        chk("R2 busy length", bc, 81);
        chk("R2 presence", presence, 1);
        chk("R2 done", done, 1);
        dev_force = 0;
        clear_flags();
        chk("R11 done cleared", done, 0);

        // R2 reset without answer, slower tick
        clk_div = 8'd3;
        exp_w.push_back(20 * 4);
        pulse_cmd(1, bc);
        chk("R2 busy length div3", bc, 161);
        chk("R2 no presence", presence, 0);
        clk_div = 8'd1;

        // R3/R4 byte write, written bits echo back
        push_tx(8'h35);
        expect_byte(8'h35, 1); exp_rx.push_back(8'h35);
        pulse_cmd(0, bc);
        chk("R4 busy length", bc, 129);
        read_rx("R4");

        // R6 byte read with device answer
        push_tx(8'hFF);
        v = 8'hA5;
        for (int i = 0; i < 8; i++) resp_q.push_back(v[i]);
        expect_byte(8'hFF, 1); exp_rx.push_back(8'hA5);
        pulse_cmd(0, bc);
        read_rx("R6");

        // R5 bit mode
        mode = 2'd0;
        push_tx(8'h02); expect_byte(8'h02, 0); exp_rx.push_back(8'h00);
        pulse_cmd(0, bc);
        chk("R5 busy length", bc, 17);
        read_rx("R5 write0");
        push_tx(8'h03); expect_byte(8'h03, 0); exp_rx.push_back(8'h01);
        pulse_cmd(0, bc);
        read_rx("R5 write1");
        push_tx(8'h01); resp_q.push_back(1'b0);
        expect_byte(8'h01, 0); exp_rx.push_back(8'h00);
        pulse_cmd(0, bc);
        read_rx("R6 bit read");

        // R12 divider factor 0
        mode = 2'd1; clk_div = 8'd0;
        push_tx(8'h0F); expect_byte(8'h0F, 1); exp_rx.push_back(8'h0F);
        pulse_cmd(0, bc);
        chk("R12 busy length", bc, 65);
        read_rx("R12");
        clk_div = 8'd1;

        // R7 queue depth and order
        for (int i = 0; i < 17; i++) push_tx(8'((i * 7 + 3) & 8'hFF));
        @(negedge clk);
        chk("R7 tx_full", tx_full, 1);
        chk("R7 tx_ovf", tx_ovf, 1);
        for (int i = 0; i < 16; i++) begin
            v = 8'((i * 7 + 3) & 8'hFF);
            expect_byte(v, 1); exp_rx.push_back(v);
            pulse_cmd(0, bc);
        end
        // R9 receive overflow
        push_tx(8'h5A); expect_byte(8'h5A, 1);
        pulse_cmd(0, bc);
        chk("R9 rx full err", err, 1);
        clear_flags();
        chk("R11 err cleared", err, 0);
        chk("R11 ovf cleared", tx_ovf, 0);
        for (int i = 0; i < 16; i++) read_rx("R7");
        @(negedge clk);
        chk("R8 empty data", rx_data, 0);
        rx_rd = 1; @(negedge clk); rx_rd = 0;
        @(negedge clk);
        chk("R8 rx_udf", rx_udf, 1);
        // R9 go on empty queue
        pulse_cmd(0, bc);
        chk("R9 no busy", bc, 0);
        chk("R9 err", err, 1);

        // R10 bypass
        mode = 2'd2;
        push_tx(8'h11);
        pulse_cmd(0, bc);
        chk("R10 go ignored", bc, 0);
        pulse_cmd(1, bc);
        chk("R10 reset ignored", bc, 0);
        exp_w.push_back(5);
        @(negedge clk); #1 bypass_drive = 1;
        @(negedge clk);
        chk("R10 drive", bus_oe, 1);
        repeat (4) @(negedge clk);
        #1 bypass_drive = 0;
        @(negedge clk);
        chk("R10 release", bus_oe, 0);
        mode = 2'd1;
        expect_byte(8'h11, 1); exp_rx.push_back(8'h11);
        pulse_cmd(0, bc);
        read_rx("R10 entry kept");

        repeat (10) @(negedge clk);
        chk("R3 all pulses seen", exp_w.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule